// File: doc/BRIEF.md
# Integer Multiply and Divide Unit

This block carries out the eight 32-bit integer multiply, divide and remainder operations that a RISC-V core with the M extension needs. A 3-bit function code selects the operation, and two 32-bit operands go with it. The caller pulses `start` for one cycle and gets back a one-cycle `done` pulse, with the 32-bit answer on `result`. Decode, register reads and hazard handling stay in the surrounding pipeline.

Multiplies take one cycle. The result is the low half of the 64-bit product, or the high half under one of three signedness rules. Divide and remainder run an iterative restoring sequence, one quotient bit per cycle, and `busy` is high while it runs. A zero divisor and a signed overflow produce fixed results in a single cycle and never raise an exception. A `start` that arrives while the unit is busy is dropped.

Top module: `muldiv_unit`

## Requirements
- R1: Function code 0 returns bits 31:0 of the product of `opa` and `opb`.
- R2: Function codes 1, 2 and 3 return bits 63:32 of the 64-bit product. Code 1 treats both operands as signed. Code 2 treats `opa` as signed and `opb` as unsigned. Code 3 treats both as unsigned.
- R3: Function code 4 (signed quotient) truncates toward zero. Function code 6 (signed remainder) returns a value that carries the sign of the dividend `opa`.
- R4: Function code 5 returns the unsigned quotient and code 7 returns the unsigned remainder.
- R5: When `opb` is zero, codes 4 and 5 return 0xFFFFFFFF and codes 6 and 7 return `opa`.
- R6: When `opa` is 0x80000000 and `opb` is 0xFFFFFFFF, code 4 returns 0x80000000 and code 6 returns 0.
- R7: An accepted multiply, zero-divisor or overflow operation raises `done` one cycle after the start cycle. Any other divide or remainder raises `done` 33 cycles after the start cycle, with `busy` high from the cycle after the start until `done` rises.
- R8: `done` is high for exactly one cycle for each accepted operation, `busy` is low while `done` is high, and `result` holds its value until the next `done`.
- R9: A `start` seen while `busy` is high is ignored. It neither produces an extra `done` nor changes the result or the timing of the running operation.
- R10: After reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, taken when `busy` is low |
| funct | input | 3 | Operation select, codes 0 to 7 |
| opa | input | 32 | First operand (multiplicand / dividend) |
| opb | input | 32 | Second operand (multiplier / divisor) |
| busy | output | 1 | Iterative divide in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 32 | Result of the last completed operation |

## Verification
Directed operands with each sign combination show whether the high-half variants and the division sign rules are kept apart: negative times all-ones, for example, gives a different high word under each of the three signedness rules. Zero divisors on all four divide codes and the most-negative/minus-one pair test the early-exit results and their one-cycle timing against the 33-cycle iterative path. A start pulse sent during a running divide checks that the request is dropped. Seeded random operands, mixed with operands that have a small divisor so that quotients are not trivially zero, are compared with a bench model built on native 64-bit arithmetic.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int MDU_XLEN = 32;

    typedef enum logic [2:0] {
        FN_MUL    = 3'd0,
        FN_MULH   = 3'd1,
        FN_MULHSU = 3'd2,
        FN_MULHU  = 3'd3,
        FN_DIV    = 3'd4,
        FN_DIVU   = 3'd5,
        FN_REM    = 3'd6,
        FN_REMU   = 3'd7
    } mdu_fn_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mdu_state_e;

    // Sign handling captured when a divide is launched
    typedef struct packed {
        logic want_rem;
        logic neg_quo;
        logic neg_rem;
    } div_ctl_t;

    function automatic logic fn_is_divide(mdu_fn_e f);
        return (f == FN_DIV) || (f == FN_DIVU) || (f == FN_REM) || (f == FN_REMU);
    endfunction

    function automatic logic fn_is_rem(mdu_fn_e f);
        return (f == FN_REM) || (f == FN_REMU);
    endfunction

    function automatic logic fn_div_signed(mdu_fn_e f);
        return (f == FN_DIV) || (f == FN_REM);
    endfunction

    function automatic logic fn_mul_a_signed(mdu_fn_e f);
        return (f == FN_MULH) || (f == FN_MULHSU);
    endfunction

    function automatic logic fn_mul_b_signed(mdu_fn_e f);
        return (f == FN_MULH);
    endfunction

endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul
    import muldiv_pkg::*;
#(
    parameter int XLEN = MDU_XLEN
) (
    input  mdu_fn_e           fn,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   res
);
    localparam int PW = 2 * XLEN;

    logic          a_sx;
    logic          b_sx;
    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] prod;

    always_comb begin
        a_sx  = fn_mul_a_signed(fn) & a[XLEN-1];
        b_sx  = fn_mul_b_signed(fn) & b[XLEN-1];
        a_ext = {{XLEN{a_sx}}, a};
        b_ext = {{XLEN{b_sx}}, b};
        // product modulo 2^PW equals the exact signed/unsigned product's low PW bits
        prod  = a_ext * b_ext;
        res   = (fn == FN_MUL) ? prod[XLEN-1:0] : prod[PW-1:XLEN];
    end
endmodule

// File: rtl/muldiv_special.sv
module muldiv_special
    import muldiv_pkg::*;
#(
    parameter int XLEN = MDU_XLEN
) (
    input  mdu_fn_e           fn,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic              hit,
    output logic [XLEN-1:0]   res
);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};

    logic zero_div;
    logic ovf;
    logic rem_op;

    always_comb begin
        rem_op   = fn_is_rem(fn);
        zero_div = fn_is_divide(fn) && (b == '0);
        ovf      = fn_div_signed(fn) && (a == MOST_NEG) && (b == ALL_ONES);
        hit      = zero_div || ovf;
        if (zero_div) begin
            res = rem_op ? a : ALL_ONES;
        end else if (ovf) begin
            res = rem_op ? '0 : MOST_NEG;
        end else begin
            res = '0;
        end
    end
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core
    import muldiv_pkg::*;
#(
    parameter int XLEN = MDU_XLEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  mdu_fn_e           fn,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic              last_step,
    output logic [XLEN-1:0]   res
);
    localparam int CNT_W = $clog2(XLEN + 1);

    div_ctl_t           ctl_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [XLEN-1:0]    quo_q;
    logic [XLEN:0]      rem_q;
    logic [XLEN-1:0]    dvs_q;

    logic               a_neg;
    logic               b_neg;
    logic [XLEN-1:0]    a_mag;
    logic [XLEN-1:0]    b_mag;

    logic [XLEN:0]      shifted;
    logic [XLEN:0]      diff;
    logic               fits;
    logic [XLEN:0]      rem_n;
    logic [XLEN-1:0]    quo_n;

    // operand magnitudes at launch
    always_comb begin
        a_neg = fn_div_signed(fn) & a[XLEN-1];
        b_neg = fn_div_signed(fn) & b[XLEN-1];
        a_mag = a_neg ? (~a + 1'b1) : a;
        b_mag = b_neg ? (~b + 1'b1) : b;
    end

    // one restoring step
    always_comb begin
        shifted = {rem_q[XLEN-1:0], quo_q[XLEN-1]};
        diff    = shifted - {1'b0, dvs_q};
        fits    = ~diff[XLEN];
        rem_n   = fits ? diff : shifted;
        quo_n   = {quo_q[XLEN-2:0], fits};
    end

    always_comb begin
        last_step = (cnt_q == CNT_W'(1));
        if (ctl_q.want_rem) begin
            res = ctl_q.neg_rem ? (~rem_n[XLEN-1:0] + 1'b1) : rem_n[XLEN-1:0];
        end else begin
            res = ctl_q.neg_quo ? (~quo_n + 1'b1) : quo_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cnt_q <= '0;
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            ctl_q.want_rem <= fn_is_rem(fn);
            ctl_q.neg_quo  <= a_neg ^ b_neg;
            ctl_q.neg_rem  <= a_neg;
            cnt_q          <= CNT_W'(XLEN);
            quo_q          <= a_mag;
            rem_q          <= '0;
            dvs_q          <= b_mag;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            quo_q <= quo_n;
            rem_q <= rem_n;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int XLEN = MDU_XLEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        funct,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   result
);
    mdu_fn_e            fn;
    mdu_state_e         state_q;
    logic               accept;
    logic               div_load;
    logic [XLEN-1:0]    mul_res;
    logic               sp_hit;
    logic [XLEN-1:0]    sp_res;
    logic               div_last;
    logic [XLEN-1:0]    div_res;
    logic               done_q;
    logic [XLEN-1:0]    res_q;

    assign fn       = mdu_fn_e'(funct);
    assign accept   = start && (state_q == ST_IDLE);
    assign div_load = accept && fn_is_divide(fn) && !sp_hit;

    muldiv_mul #(.XLEN(XLEN)) u_mul (
        .fn  (fn),
        .a   (opa),
        .b   (opb),
        .res (mul_res)
    );

    muldiv_special #(.XLEN(XLEN)) u_special (
        .fn  (fn),
        .a   (opa),
        .b   (opb),
        .hit (sp_hit),
        .res (sp_res)
    );

    muldiv_div_core #(.XLEN(XLEN)) u_div (
        .clk       (clk),
        .rst       (rst),
        .load      (div_load),
        .fn        (fn),
        .a         (opa),
        .b         (opb),
        .last_step (div_last),
        .res       (div_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (div_load) begin
                        state_q <= ST_RUN;
                    end else if (accept) begin
                        done_q <= 1'b1;
                        res_q  <= sp_hit ? sp_res : mul_res;
                    end
                end
                ST_RUN: begin
                    if (div_last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        res_q   <= div_res;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state_q == ST_RUN);
    assign done   = done_q;
    assign result = res_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [2:0]      funct,
    input logic [XLEN-1:0] opa,
    input logic [XLEN-1:0] opb,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result
);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};

    AST_MUL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !funct[2]) |=> done); // R7

    AST_DIVZERO_QUOT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && funct[2] && !funct[1] && opb == '0) |=> (done && result == ALL_ONES)); // R5

    AST_DIVZERO_REM: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && funct[2] && funct[1] && opb == '0) |=> (done && result == $past(opa))); // R5

    AST_SIGNED_OVF: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && funct == 3'd4 && opa == MOST_NEG && opb == ALL_ONES) |=> (done && result == MOST_NEG)); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |=> (done || $stable(result))); // R8

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy || done)); // R9

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(start) || $past(busy))); // R9
endmodule

bind muldiv_unit muldiv_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .funct  (funct),
    .opa    (opa),
    .opb    (opb),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  funct = 3'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy;
    logic        done;
    logic [31:0] result;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    muldiv_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .funct(funct),
        .opa(opa), .opb(opb), .busy(busy), .done(done), .result(result)
    );

    function automatic logic [31:0] ref_op(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
        longint      sa;
        longint      sb;
        longint      ub;
        longint      p;
        logic [63:0] pu;
        int          q;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ub = longint'({32'd0, b});
        case (f)
            3'd0: begin p = sa * sb; return p[31:0]; end
            3'd1: begin p = sa * sb; return p[63:32]; end
            3'd2: begin p = sa * ub; return p[63:32]; end
            3'd3: begin pu = {32'd0, a} * {32'd0, b}; return pu[63:32]; end
            3'd4: begin
                if (b == 0) return 32'hFFFF_FFFF;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return a;
                q = $signed(a) / $signed(b);
                return q;
            end
            3'd5: return (b == 0) ? 32'hFFFF_FFFF : a / b;
            3'd6: begin
                if (b == 0) return a;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'd0;
                q = $signed(a) % $signed(b);
                return q;
            end
            default: return (b == 0) ? a : a % b;
        endcase
    endfunction

    function automatic int ref_lat(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
        if (!f[2] || b == 0) return 1;
        if (!f[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 1;
        return 33;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, count edges until done is seen
    task automatic run_op(input string tag, input logic [2:0] f, input logic [31:0] a, input logic [31:0] b,
                          input bit poke_busy);
        int lat;
        logic [31:0] held;
        @(negedge clk);
        start = 1'b1; funct = f; opa = a; opb = b;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) begin
                if (poke_busy) begin
                    // R9: new request while busy must be dropped
                    funct = 3'd0; opa = 32'd3; opb = 32'd5;
                end else begin
                    start = 1'b0;
                end
            end
            if (lat == 3) start = 1'b0;
            if (lat > 1 && !done) check({tag, " R7 busy during divide"}, {31'd0, busy}, 32'd1);
        end while (!done && lat < 100);
        start = 1'b0;
        check({tag, " result"}, result, ref_op(f, a, b));
        check({tag, " R7 latency"}, lat, ref_lat(f, a, b));
        check({tag, " R8 not busy at done"}, {31'd0, busy}, 32'd0);
        held = result;
        @(negedge clk);
        check({tag, " R8 done one cycle"}, {31'd0, done}, 32'd0);
        check({tag, " R8 result held"}, result, held);
    endtask

    initial begin
        while (cycles < MAX_CYCLES) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, MAX_CYCLES);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] ra;
        logic [31:0] rb;
        logic [2:0]  rf;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check("R10 busy after reset", {31'd0, busy}, 32'd0);
        check("R10 done after reset", {31'd0, done}, 32'd0);
        check("R10 result after reset", result, 32'd0);

        run_op("R1 small", 3'd0, 32'd3, 32'd5, 1'b0);
        run_op("R1 negative", 3'd0, 32'hFFFF_FFF9, 32'd6, 1'b0);
        run_op("R2 mulh neg neg", 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op("R2 mulhsu neg ones", 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op("R2 mulhu ones", 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op("R2 mulh min min", 3'd1, 32'h8000_0000, 32'h8000_0000, 1'b0);
        run_op("R3 div -7/2", 3'd4, 32'hFFFF_FFF9, 32'd2, 1'b0);
        run_op("R3 div 7/-2", 3'd4, 32'd7, 32'hFFFF_FFFE, 1'b0);
        run_op("R3 rem -7%2", 3'd6, 32'hFFFF_FFF9, 32'd2, 1'b0);
        run_op("R3 rem 7%-2", 3'd6, 32'd7, 32'hFFFF_FFFE, 1'b0);
        run_op("R4 divu big", 3'd5, 32'hFFFF_FFF9, 32'd2, 1'b0);
        run_op("R4 remu big", 3'd7, 32'hFFFF_FFF9, 32'd10, 1'b0);
        run_op("R4 divu by one", 3'd5, 32'h8000_0001, 32'd1, 1'b0);
        run_op("R5 div by zero", 3'd4, 32'h1234_5678, 32'd0, 1'b0);
        run_op("R5 divu by zero", 3'd5, 32'd0, 32'd0, 1'b0);
        run_op("R5 rem by zero", 3'd6, 32'h8765_4321, 32'd0, 1'b0);
        run_op("R5 remu by zero", 3'd7, 32'hCAFE_0001, 32'd0, 1'b0);
        run_op("R6 div overflow", 3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_op("R6 rem overflow", 3'd6, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_op("R6 divu not overflow", 3'd5, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_op("R9 start while busy", 3'd4, 32'd1000, 32'hFFFF_FFF9, 1'b1);

        for (int i = 0; i < 400; i++) begin
            ra = $urandom();
            rb = $urandom();
            rf = 3'($urandom_range(7, 0));
            if (i % 4 == 1) rb = 32'($urandom_range(9, 0));
            if (i % 8 == 3) rb = -32'($urandom_range(9, 1));
            run_op((rf[2] ? "R3/R4 random divide" : "R1/R2 random multiply"), rf, ra, rb, (i % 16 == 5));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule